// File: doc/BRIEF.md
# Security Context Register Unit

This block holds the security-context configurations for a single hardware thread. It also carries out the operations that manage them. Each slot in the bank stores three fields:

- a 64-bit random identity key;
- a 32-bit entry-point address;
- a 32-bit capability word.

Slot 0 always describes the context that is running now. No single field of slot 0 can be written. The only way to change slot 0 is to copy a whole slot into it.

Software prepares another context in three steps. First it gives a spare slot a fresh key from the random source, which marks that slot as newly keyed. Next it fills in the slot's entry point and capabilities. Finally it copies the slot into slot 0. That copy is the one legal way to make an indirect jump. The unit then redirects the program counter to the new entry point. When the key changes, it also pulses a flush request so the shared microarchitectural state can be cleaned between security domains. Any operation that breaks these rules raises an illegal-operation fault and leaves the bank untouched.

Every operation is presented for one cycle with `op_valid` high. All outputs are registered, so each result appears one clock edge later.

Top module: `hsc_unit`

## Requirements
- R1: After reset every slot holds zero in all fields with its new flag clear, and `rd_data`, `pc_valid`, `pc_target`, `flush` and `fault` are all zero.
- R2: Opcode 2 (key generation) to a slot other than 0 loads `rnd_key` into that slot's key and marks it new. A read (opcode 1) with field 0 returns key bits 31:0, and with field 1 returns key bits 63:32.
- R3: Opcode 3 (write entry) and opcode 4 (write capabilities) to a slot marked new store `wdata`. A read returns the entry point with field 2 and the capabilities with field 3.
- R4: An entry or capability write to a slot that is not marked new raises `fault` for one cycle and changes nothing.
- R5: Key generation, entry write or capability write aimed at slot 0 raises `fault` and leaves slot 0 unchanged.
- R6: Opcode 5 (move) copies all three fields from the source slot to the destination slot and clears the new flag of both slots. Later field writes to either slot therefore fault.
- R7: A move whose destination is slot 0 pulses `pc_valid` for one cycle, with `pc_target` equal to the source slot's entry point. No other operation asserts `pc_valid`.
- R8: `flush` pulses together with `pc_valid`, and only when the incoming key differs from the key slot 0 held before the move.
- R9: Opcodes 6 and 7 are undefined. They raise `fault` and change no state.
- R10: With `op_valid` low, or with opcode 0 (no operation), the unit raises no output pulse and changes no state. The outputs `fault`, `pc_valid` and `flush` each last a single cycle per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation: 0 none, 1 read, 2 key gen, 3 write entry, 4 write caps, 5 move |
| src_idx | input | 2 | Source slot (read, move) |
| dst_idx | input | 2 | Destination slot (key gen, writes, move) |
| field_sel | input | 2 | Read field: 0 key low, 1 key high, 2 entry, 3 caps |
| wdata | input | 32 | Register operand for entry or capability writes |
| rnd_key | input | 64 | Random number source sampled by key generation |
| rd_data | output | 32 | Last read result |
| pc_valid | output | 1 | Context switch: redirect the PC |
| pc_target | output | 32 | New program counter on a switch |
| flush | output | 1 | Domain changed: flush shared resources |
| fault | output | 1 | Illegal operation |

## Verification
The assertions assume that `op_code`, `src_idx` and `dst_idx` are known whenever `op_valid` is high. They also assume that `op_valid` is held low during reset, because each pulse is traced back to the operation sampled one cycle earlier. The stimulus follows both rules. It changes inputs only at the falling edge, drives one operation per cycle, and keeps `op_valid` low through every reset. It also issues undefined opcodes and idle cycles with a move pattern on the other inputs, so that the no-effect properties are exercised and do not hold merely because those inputs never occur.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    parameter int NUM_CTX = 4;
    parameter int KEY_W   = 64;
    parameter int ADDR_W  = 32;
    parameter int CAP_W   = 32;

    localparam int IDX_W  = $clog2(NUM_CTX);
    localparam int DATA_W = ADDR_W;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 3'd0,
        OP_READ   = 3'd1,
        OP_GENKEY = 3'd2,
        OP_WENTRY = 3'd3,
        OP_WCAP   = 3'd4,
        OP_MOVE   = 3'd5
    } op_e;

    typedef struct packed {
        logic [KEY_W-1:0]  key;
        logic [ADDR_W-1:0] entry;
        logic [CAP_W-1:0]  caps;
    } ctx_t;

    typedef struct packed {
        logic legal;
        logic do_read;
        logic do_genkey;
        logic do_wentry;
        logic do_wcap;
        logic do_move;
        logic do_switch;
    } cmd_t;

    // Field selector for reads: 0 key low, 1 key high, 2 entry, 3 caps.
    function automatic logic [DATA_W-1:0] field_of(ctx_t c, logic [1:0] sel);
        logic [DATA_W-1:0] r;
        case (sel)
            2'd0:    r = c.key[DATA_W-1:0];
            2'd1:    r = c.key[KEY_W-1:KEY_W-DATA_W];
            2'd2:    r = c.entry;
            default: r = DATA_W'(c.caps);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hsc_decode.sv
module hsc_decode
    import hsc_pkg::*;
(
    input  logic               op_valid,
    input  logic [OP_W-1:0]    op_code,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic [NUM_CTX-1:0] new_flags,
    output cmd_t               cmd
);
    logic dst_is_cur;
    logic dst_is_new;
    logic legal_op;

    assign dst_is_cur = (dst_idx == '0);
    assign dst_is_new = new_flags[dst_idx];

    always_comb begin
        case (op_e'(op_code))
            OP_NOP, OP_READ, OP_MOVE: legal_op = 1'b1;
            OP_GENKEY:                legal_op = !dst_is_cur;
            OP_WENTRY, OP_WCAP:       legal_op = !dst_is_cur && dst_is_new;
            default:                  legal_op = 1'b0;
        endcase
    end

    always_comb begin
        cmd           = '0;
        cmd.legal     = !op_valid || legal_op;
        if (op_valid && legal_op) begin
            cmd.do_read   = (op_e'(op_code) == OP_READ);
            cmd.do_genkey = (op_e'(op_code) == OP_GENKEY);
            cmd.do_wentry = (op_e'(op_code) == OP_WENTRY);
            cmd.do_wcap   = (op_e'(op_code) == OP_WCAP);
            cmd.do_move   = (op_e'(op_code) == OP_MOVE);
            cmd.do_switch = (op_e'(op_code) == OP_MOVE) && dst_is_cur;
        end
    end

endmodule

// File: rtl/hsc_bank.sv
module hsc_bank
    import hsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cmd_t               cmd,
    input  logic [IDX_W-1:0]   src_idx,
    input  logic [IDX_W-1:0]   dst_idx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [KEY_W-1:0]   rnd_key,
    output ctx_t               slots     [NUM_CTX],
    output logic [NUM_CTX-1:0] new_flags
);
    ctx_t src_ctx;
    assign src_ctx = slots[src_idx];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
        logic hit_dst;
        logic hit_src;
        assign hit_dst = (dst_idx == IDX_W'(i));
        assign hit_src = (src_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i]     <= '0;
                new_flags[i] <= 1'b0;
            end else begin
                if (cmd.do_move && hit_dst) begin
                    slots[i] <= src_ctx;
                end else if (cmd.do_genkey && hit_dst) begin
                    slots[i].key <= rnd_key;
                end else if (cmd.do_wentry && hit_dst) begin
                    slots[i].entry <= wdata[ADDR_W-1:0];
                end else if (cmd.do_wcap && hit_dst) begin
                    slots[i].caps <= CAP_W'(wdata);
                end

                if (cmd.do_move && (hit_dst || hit_src)) begin
                    new_flags[i] <= 1'b0;
                end else if (cmd.do_genkey && hit_dst) begin
                    new_flags[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/hsc_unit.sv
module hsc_unit
    import hsc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_valid,
    input  logic [2:0]              op_code,
    input  logic [1:0]              src_idx,
    input  logic [1:0]              dst_idx,
    input  logic [1:0]              field_sel,
    input  logic [31:0]             wdata,
    input  logic [63:0]             rnd_key,
    output logic [31:0]             rd_data,
    output logic                    pc_valid,
    output logic [31:0]             pc_target,
    output logic                    flush,
    output logic                    fault
);
    cmd_t               cmd;
    ctx_t               slots [NUM_CTX];
    logic [NUM_CTX-1:0] new_flags;
    ctx_t               src_ctx;
    logic               key_changes;

    hsc_decode i_decode (
        .op_valid  (op_valid),
        .op_code   (op_code),
        .dst_idx   (dst_idx),
        .new_flags (new_flags),
        .cmd       (cmd)
    );

    hsc_bank i_bank (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .src_idx   (src_idx),
        .dst_idx   (dst_idx),
        .wdata     (wdata),
        .rnd_key   (rnd_key),
        .slots     (slots),
        .new_flags (new_flags)
    );

    assign src_ctx     = slots[src_idx];
    assign key_changes = (src_ctx.key != slots[0].key);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            pc_valid  <= 1'b0;
            pc_target <= '0;
            flush     <= 1'b0;
            fault     <= 1'b0;
        end else begin
            fault    <= !cmd.legal;
            pc_valid <= cmd.do_switch;
            flush    <= cmd.do_switch && key_changes;
            if (cmd.do_switch) begin
                pc_target <= src_ctx.entry;
            end
            if (cmd.do_read) begin
                rd_data <= field_of(src_ctx, field_sel);
            end
        end
    end

endmodule

// File: rtl/hsc_unit_chk.sv
module hsc_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic [1:0] dst_idx,
    input logic       pc_valid,
    input logic       flush,
    input logic       fault
);
    // R7: a redirect only follows a move into slot 0
    a_r7_switch_from_move: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> $past(op_valid && op_code == 3'd5 && dst_idx == 2'd0));

    // R8: flush never appears without a switch
    a_r8_flush_with_switch: assert property (@(posedge clk) disable iff (rst)
        flush |-> pc_valid);

    // R5: field writes to slot 0 fault
    a_r5_slot0_write_faults: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd4)
         && dst_idx == 2'd0) |=> fault);

    // R9: undefined opcodes fault and never switch
    a_r9_undefined_faults: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code > 3'd5) |=> (fault && !pc_valid));

    // R10: idle cycles produce no pulse
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!fault && !pc_valid && !flush));

    // R10: fault and switch are exclusive
    a_r10_onehot_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault, pc_valid}));
endmodule

bind hsc_unit hsc_unit_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .dst_idx  (dst_idx),
    .pc_valid (pc_valid),
    .flush    (flush),
    .fault    (fault)
);

// File: tb/test_hsc_unit.sv
module test_hsc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [1:0]  src_idx, dst_idx, field_sel;
    logic [31:0] wdata;
    logic [63:0] rnd_key;
    logic [31:0] rd_data, pc_target;
    logic        pc_valid, flush, fault;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    hsc_unit i_hsc_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .src_idx(src_idx), .dst_idx(dst_idx), .field_sel(field_sel),
        .wdata(wdata), .rnd_key(rnd_key), .rd_data(rd_data),
        .pc_valid(pc_valid), .pc_target(pc_target), .flush(flush), .fault(fault)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [1:0]  src;
        logic [1:0]  dst;
        logic [1:0]  fld;
        logic [31:0] wd;
        logic [63:0] rnd;
        logic        efault;
        logic        epcv;
        logic        eflush;
        logic [31:0] erd;
        logic [31:0] epc;
    } vec_t;

    localparam logic [63:0] K1 = 64'hA5A5_0001_1234_5678;
    localparam logic [63:0] K2 = 64'h0F0F_2222_9ABC_DEF0;
    localparam int NV = 28;

    localparam vec_t VECS [NV] = '{
        '{4'd1,  3'd1, 2'd0, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0},    // R1 read slot 0
        '{4'd2,  3'd2, 2'd0, 2'd1, 2'd0, 32'h0,    K1,    1'b0, 1'b0, 1'b0, 32'h0,         32'h0},    // R2 keygen slot 1
        '{4'd2,  3'd1, 2'd1, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h0},    // R2 key low
        '{4'd2,  3'd1, 2'd1, 2'd0, 2'd1, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'hA5A5_0001, 32'h0},    // R2 key high
        '{4'd3,  3'd3, 2'd0, 2'd1, 2'd0, 32'h1000, 64'h0, 1'b0, 1'b0, 1'b0, 32'hA5A5_0001, 32'h0},    // R3 write entry
        '{4'd3,  3'd4, 2'd0, 2'd1, 2'd0, 32'hFF,   64'h0, 1'b0, 1'b0, 1'b0, 32'hA5A5_0001, 32'h0},    // R3 write caps
        '{4'd3,  3'd1, 2'd1, 2'd0, 2'd2, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h1000,      32'h0},    // R3 read entry
        '{4'd3,  3'd1, 2'd1, 2'd0, 2'd3, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'hFF,        32'h0},    // R3 read caps
        '{4'd4,  3'd3, 2'd0, 2'd2, 2'd0, 32'hBAD,  64'h0, 1'b1, 1'b0, 1'b0, 32'hFF,        32'h0},    // R4 not-new write
        '{4'd4,  3'd1, 2'd2, 2'd0, 2'd2, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0},    // R4 unchanged
        '{4'd5,  3'd2, 2'd0, 2'd0, 2'd0, 32'h0,    K2,    1'b1, 1'b0, 1'b0, 32'h0,         32'h0},    // R5 keygen slot 0
        '{4'd5,  3'd4, 2'd0, 2'd0, 2'd0, 32'h5,    64'h0, 1'b1, 1'b0, 1'b0, 32'h0,         32'h0},    // R5 caps slot 0
        '{4'd5,  3'd1, 2'd0, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0},    // R5 key 0 intact
        '{4'd6,  3'd5, 2'd1, 2'd2, 2'd0, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h0,         32'h0},    // R6 move 1->2
        '{4'd6,  3'd1, 2'd2, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h0},    // R6 key copied
        '{4'd6,  3'd1, 2'd2, 2'd0, 2'd3, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'hFF,        32'h0},    // R6 caps copied
        '{4'd6,  3'd4, 2'd0, 2'd2, 2'd0, 32'h7,    64'h0, 1'b1, 1'b0, 1'b0, 32'hFF,        32'h0},    // R6 dst not new
        '{4'd6,  3'd3, 2'd0, 2'd1, 2'd0, 32'h7,    64'h0, 1'b1, 1'b0, 1'b0, 32'hFF,        32'h0},    // R6 src not new
        '{4'd8,  3'd5, 2'd2, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b1, 1'b1, 32'hFF,        32'h1000}, // R7 R8 switch
        '{4'd7,  3'd1, 2'd0, 2'd0, 2'd2, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h1000,      32'h0},    // R7 slot0 entry
        '{4'd8,  3'd5, 2'd1, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b1, 1'b0, 32'h1000,      32'h1000}, // R8 same key
        '{4'd9,  3'd6, 2'd1, 2'd0, 2'd0, 32'h0,    64'h0, 1'b1, 1'b0, 1'b0, 32'h1000,      32'h0},    // R9 op 6
        '{4'd9,  3'd7, 2'd3, 2'd0, 2'd0, 32'h0,    64'h0, 1'b1, 1'b0, 1'b0, 32'h1000,      32'h0},    // R9 op 7
        '{4'd2,  3'd2, 2'd0, 2'd3, 2'd0, 32'h0,    K2,    1'b0, 1'b0, 1'b0, 32'h1000,      32'h0},    // R2 keygen slot 3
        '{4'd3,  3'd3, 2'd0, 2'd3, 2'd0, 32'h2000, 64'h0, 1'b0, 1'b0, 1'b0, 32'h1000,      32'h0},    // R3 entry slot 3
        '{4'd8,  3'd5, 2'd3, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b1, 1'b1, 32'h1000,      32'h2000}, // R8 new key flush
        '{4'd7,  3'd1, 2'd0, 2'd0, 2'd1, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h0F0F_2222, 32'h0},    // R7 slot0 key high
        '{4'd10, 3'd0, 2'd3, 2'd0, 2'd0, 32'h0,    64'h0, 1'b0, 1'b0, 1'b0, 32'h0F0F_2222, 32'h0}     // R10 nop
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] s,
                         input logic [1:0] d, input logic [1:0] f,
                         input logic [31:0] w, input logic [63:0] k);
        op_valid = v; op_code = op; src_idx = s; dst_idx = d;
        field_sel = f; wdata = w; rnd_key = k;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic check_idle(input int req);
        check(req, "fault",    32'(fault),    32'h0);
        check(req, "pc_valid", 32'(pc_valid), 32'h0);
        check(req, "flush",    32'(flush),    32'h0);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = '0; src_idx = '0; dst_idx = '0;
        field_sel = '0; wdata = '0; rnd_key = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset outputs
        check_idle(1);
        check(1, "rd_data",   rd_data,   32'h0);
        check(1, "pc_target", pc_target, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].src, VECS[i].dst, VECS[i].fld,
                  VECS[i].wd, VECS[i].rnd);
            check(int'(VECS[i].req), "fault",    32'(fault),    32'(VECS[i].efault));
            check(int'(VECS[i].req), "pc_valid", 32'(pc_valid), 32'(VECS[i].epcv));
            check(int'(VECS[i].req), "flush",    32'(flush),    32'(VECS[i].eflush));
            check(int'(VECS[i].req), "rd_data",  rd_data,       VECS[i].erd);
            if (VECS[i].epcv) check(int'(VECS[i].req), "pc_target", pc_target, VECS[i].epc);
        end

        // R10 single-cycle pulse: the cycle after a switch is quiet
        drive(1'b1, 3'd5, 2'd1, 2'd0, 2'd0, 32'h0, 64'h0);
        check(10, "switch pulse", 32'(pc_valid), 32'h1);
        check(8,  "flush on key change", 32'(flush), 32'h1);
        drive(1'b0, 3'd0, 2'd0, 2'd0, 2'd0, 32'h0, 64'h0);
        check_idle(10);

        // R10 op_valid low with a move into slot 0 on the bus
        drive(1'b0, 3'd5, 2'd3, 2'd0, 2'd0, 32'h0, 64'h0);
        check_idle(10);
        drive(1'b1, 3'd1, 2'd0, 2'd0, 2'd2, 32'h0, 64'h0);
        check(10, "slot0 entry kept", rd_data, 32'h1000);

        // R1 reset in mid-run clears the bank
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle(1);
        check(1, "rd_data after reset", rd_data, 32'h0);
        drive(1'b1, 3'd1, 2'd1, 2'd0, 2'd0, 32'h0, 64'h0);
        check(1, "slot1 key cleared", rd_data, 32'h0);
        drive(1'b1, 3'd3, 2'd0, 2'd1, 2'd0, 32'h9, 64'h0);
        check(1, "new flag cleared", 32'(fault), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule